// File: doc/BRIEF.md
# Program and Erase Status Word Generator

This block forms the byte that a nonvolatile memory returns on a read while an embedded program or erase is running, is suspended, or is still collecting sector addresses. Some status bits invert on each read access rather than on each clock. Their meaning depends on the current operation and on whether the read address falls in a sector marked for erase. When no operation is pending, the block passes array data straight through. It also does this for a suspended-erase read outside the marked sectors.

The block owns two cycle timers. The sector-load window opens on each accepted sector-address write and closes a fixed time later, emitting a start pulse for the erase engine. The protected-program window makes the toggle bit run briefly when a program hits a locked area. The pulse engine itself lies outside this block; its state arrives on the busy, suspend and time-out inputs.

Top module: `pe_status_gen`

## Requirements
- R1: While `prog_busy` is high, `rd_data[7]` equals the inverse of `last_data[7]`. Once `prog_busy` falls with nothing else pending, reads return `array_data`, so the true programmed value appears.
- R2: While the load window is open or `erase_busy` is high, `rd_data[7]` is 0. After the erase ends, reads return `array_data`; an erased byte reads 0xFF.
- R3: In program or erase state, `rd_data[6]` inverts after every read strobe, at any address. In suspended state it holds its value across reads.
- R4: In erase or suspended state, `rd_data[2]` inverts after a read strobe only when `sect_sel` is 1. A strobe with `sect_sel` at 0 leaves it unchanged.
- R5: In program or erase state, `rd_data[5]` equals `time_over`. While `time_over` is 1, `rd_data[6]` keeps inverting on each read.
- R6: In erase state, `rd_data[3]` is 0 while the load window is open. It is 1 when `erase_busy` is high and the window is closed.
- R7: A `sect_wr` pulse opens the window (`win_open`=1). The window lasts exactly WIN_US*CLK_MHZ cycles after the last `sect_wr`, and each new `sect_wr` restarts the count. `win_go` is high for the single cycle in which the window has just closed.
- R8: A `sect_wr` arriving while `erase_busy` is high does not open the window.
- R9: A `prot_hit` pulse puts the block in program state for PROT_US*CLK_MHZ cycles, with bit 6 inverting on reads. After that, reads return `array_data`.
- R10: In any status state, bits 4, 1 and 0 are 0. With no operation, window or protection timer active, and no suspended read of a marked sector, `rd_data` equals `array_data`.
- R11: While suspended (`erase_susp`=1 and neither busy input high, window closed), a read with `sect_sel`=1 returns bit 7 = 1, bit 6 held, bit 2 toggling, and all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_busy | input | 1 | Embedded program running |
| erase_busy | input | 1 | Erase proper running |
| erase_susp | input | 1 | Erase suspended |
| time_over | input | 1 | Pulse-count limit exceeded |
| sect_wr | input | 1 | Accepted sector-address write (one cycle) |
| prot_hit | input | 1 | Program aimed at protected area (one cycle) |
| sect_sel | input | 1 | Current read address is in a marked sector |
| rd_stb | input | 1 | One read access this cycle |
| last_data | input | 8 | Byte most recently given to program |
| array_data | input | 8 | Array content at the read address |
| rd_data | output | 8 | Byte returned to the reader |
| win_open | output | 1 | Sector-load window open |
| win_go | output | 1 | Window just closed; start erase |

## Verification
A wrong toggle register shows at the very next strobed read: bit 6 or bit 2 fails to invert, or inverts when it should hold. A mode decode error changes bit 7 or bit 3 immediately, in the same cycle as the offending input. A timer fault is visible only at the window edges, so `win_open` is sampled exactly one cycle before and at the expected close, after a restart in mid-window.

// File: rtl/pe_status_pkg.sv
package pe_status_pkg;

  typedef enum logic [1:0] {
    SM_ARRAY = 2'd0,
    SM_PROG  = 2'd1,
    SM_ERASE = 2'd2,
    SM_SUSP  = 2'd3
  } stat_mode_e;

  function automatic int unsigned us_cycles(input int unsigned mhz, input int unsigned us);
    return mhz * us;
  endfunction

  // program (or protect timer) beats erase, erase beats suspend
  function automatic stat_mode_e pick_mode(input logic prog_like, input logic erase_like,
                                           input logic susp, input logic sel);
    if (prog_like)        return SM_PROG;
    else if (erase_like)  return SM_ERASE;
    else if (susp && sel) return SM_SUSP;
    else                  return SM_ARRAY;
  endfunction

  function automatic logic [7:0] form_word(input stat_mode_e m, input logic d7,
                                           input logic t6, input logic t2,
                                           input logic tmo, input logic started,
                                           input logic [7:0] arr);
    logic [7:0] w;
    w = 8'h00;
    case (m)
      SM_PROG:  begin w[7] = ~d7;  w[6] = t6; w[5] = tmo; end
      SM_ERASE: begin w[7] = 1'b0; w[6] = t6; w[5] = tmo; w[3] = started; w[2] = t2; end
      SM_SUSP:  begin w[7] = 1'b1; w[6] = t6; w[2] = t2; end
      default:  w = arr;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/pe_cycle_window.sv
module pe_cycle_window #(
  parameter int unsigned CYCLES = 6000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic inhibit,
  output logic open
);
  localparam int unsigned CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOADV = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open <= 1'b0;
      cnt  <= '0;
    end else if (start && !inhibit) begin
      open <= 1'b1;
      cnt  <= LOADV;
    end else if (open) begin
      if (cnt == '0) open <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/pe_toggle_pair.sv
module pe_toggle_pair (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_stb,
  input  logic en6,
  input  logic en2,
  output logic t6,
  output logic t2
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t6 <= 1'b0;
      t2 <= 1'b0;
    end else if (rd_stb) begin
      if (en6) t6 <= ~t6;
      if (en2) t2 <= ~t2;
    end
  end
endmodule

// File: rtl/pe_word_mux.sv
module pe_word_mux
  import pe_status_pkg::*;
(
  input  stat_mode_e mode,
  input  logic       d7,
  input  logic       t6,
  input  logic       t2,
  input  logic       tmo,
  input  logic       started,
  input  logic [7:0] arr,
  output logic [7:0] word
);
  always_comb word = form_word(mode, d7, t6, t2, tmo, started, arr);
endmodule

// File: rtl/pe_status_gen.sv
module pe_status_gen
  import pe_status_pkg::*;
#(
  parameter int unsigned CLK_MHZ = 200,
  parameter int unsigned WIN_US  = 30,
  parameter int unsigned PROT_US = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       prog_busy,
  input  logic       erase_busy,
  input  logic       erase_susp,
  input  logic       time_over,
  input  logic       sect_wr,
  input  logic       prot_hit,
  input  logic       sect_sel,
  input  logic       rd_stb,
  input  logic [7:0] last_data,
  input  logic [7:0] array_data,
  output logic [7:0] rd_data,
  output logic       win_open,
  output logic       win_go
);
  localparam int unsigned WIN_CYC  = us_cycles(CLK_MHZ, WIN_US);
  localparam int unsigned PROT_CYC = us_cycles(CLK_MHZ, PROT_US);

  logic       prot_active;
  logic       win_open_q;
  stat_mode_e mode;
  logic       in_status;
  logic       mode_susp;
  logic       tog6_en;
  logic       tog2_en;
  logic       t6;
  logic       t2;
  logic       erase_started;

  pe_cycle_window #(.CYCLES(WIN_CYC)) u_load_win (
    .clk(clk), .rst_n(rst_n), .start(sect_wr), .inhibit(erase_busy), .open(win_open)
  );

  pe_cycle_window #(.CYCLES(PROT_CYC)) u_prot_win (
    .clk(clk), .rst_n(rst_n), .start(prot_hit), .inhibit(1'b0), .open(prot_active)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_open_q <= 1'b0;
    else        win_open_q <= win_open;
  end
  assign win_go = win_open_q & ~win_open;

  assign mode = pick_mode(prog_busy | prot_active, erase_busy | win_open,
                          erase_susp, sect_sel);
  assign in_status     = (mode != SM_ARRAY);
  assign mode_susp     = (mode == SM_SUSP);
  assign tog6_en       = (mode == SM_PROG) || (mode == SM_ERASE);
  assign tog2_en       = ((mode == SM_ERASE) || mode_susp) && sect_sel;
  assign erase_started = erase_busy & ~win_open;

  pe_toggle_pair u_tog (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .en6(tog6_en), .en2(tog2_en),
    .t6(t6), .t2(t2)
  );

  pe_word_mux u_mux (
    .mode(mode), .d7(last_data[7]), .t6(t6), .t2(t2), .tmo(time_over),
    .started(erase_started), .arr(array_data), .word(rd_data)
  );
endmodule

// File: rtl/pe_status_chk.sv
module pe_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       prog_busy,
  input logic       erase_busy,
  input logic       erase_susp,
  input logic       time_over,
  input logic       rd_stb,
  input logic [7:0] last_data,
  input logic [7:0] array_data,
  input logic [7:0] rd_data,
  input logic       win_open,
  input logic       win_go,
  input logic       prot_active,
  input logic       in_status,
  input logic       mode_susp
);
  p_prog_q7_r1: assert property (@(posedge clk) disable iff (!rst_n)
    prog_busy |-> rd_data[7] == ~last_data[7]);

  p_erase_q7_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_busy && !prog_busy && !prot_active) |-> rd_data[7] == 1'b0);

  p_q6_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && prog_busy) ##1 prog_busy |-> rd_data[6] != $past(rd_data[6]));

  p_q6_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mode_susp ##1 mode_susp |-> $stable(rd_data[6]));

  p_tmo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_busy && time_over) |-> rd_data[5]);

  p_win_close_r7: assert property (@(posedge clk) disable iff (!rst_n)
    win_go |-> (!win_open && $past(win_open)));

  p_no_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_busy && !win_open) |=> !win_open);

  p_zero_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_status |-> (rd_data[4] == 1'b0 && rd_data[1:0] == 2'b00));

  p_idle_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!prog_busy && !erase_busy && !win_open && !erase_susp && !prot_active)
      |-> rd_data == array_data);
endmodule

bind pe_status_gen pe_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .prog_busy(prog_busy), .erase_busy(erase_busy),
  .erase_susp(erase_susp), .time_over(time_over), .rd_stb(rd_stb),
  .last_data(last_data), .array_data(array_data), .rd_data(rd_data),
  .win_open(win_open), .win_go(win_go), .prot_active(prot_active),
  .in_status(in_status), .mode_susp(mode_susp)
);

// File: tb/pe_status_gen_test.sv
`timescale 1ns/1ps
module pe_status_gen_test;
  localparam int WINC  = 200 * 30;
  localparam int PROTC = 200 * 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prog_busy = 0, erase_busy = 0, erase_susp = 0, time_over = 0;
  logic sect_wr = 0, prot_hit = 0, sect_sel = 0, rd_stb = 0;
  logic [7:0] last_data = 8'h00, array_data = 8'h00;
  logic [7:0] rd_data;
  logic win_open, win_go;

  int n_cmp = 0, n_bad = 0;
  logic m6 = 1'b0, m2 = 1'b0;
  logic [7:0] expq[$];
  string      tagq[$];

  always #2.5 clk = ~clk;

  pe_status_gen uut (
    .clk(clk), .rst_n(rst_n), .prog_busy(prog_busy), .erase_busy(erase_busy),
    .erase_susp(erase_susp), .time_over(time_over), .sect_wr(sect_wr),
    .prot_hit(prot_hit), .sect_sel(sect_sel), .rd_stb(rd_stb),
    .last_data(last_data), .array_data(array_data), .rd_data(rd_data),
    .win_open(win_open), .win_go(win_go)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected byte per strobed read
  always @(negedge clk) begin
    if (rst_n && rd_stb) begin
      if (expq.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL scoreboard: read with no expected value, got %02h expected none", rd_data);
      end else begin
        chk(rd_data, expq.pop_front(), tagq.pop_front());
      end
    end
  end

  task automatic do_read(input logic [7:0] exp, input string tag);
    @(posedge clk); #1;
    rd_stb = 1'b1;
    expq.push_back(exp);
    tagq.push_back(tag);
    @(posedge clk); #1;
    rd_stb = 1'b0;
  endtask

  function automatic logic [7:0] w_prog(input logic d7, input logic b6, input logic b5);
    return {~d7, b6, b5, 5'b0};
  endfunction
  function automatic logic [7:0] w_erase(input logic b6, input logic b5, input logic b3, input logic b2);
    return {1'b0, b6, b5, 1'b0, b3, b2, 2'b0};
  endfunction

  task automatic pulse_sect;
    @(posedge clk); #1 sect_wr = 1'b1;
    @(posedge clk); #1 sect_wr = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    array_data = 8'h5A;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(rd_data, 8'h5A, "R10 reset passthrough");
    chk({7'b0, win_open}, 8'h00, "R7 window closed at reset");

    // program
    last_data = 8'h80; prog_busy = 1'b1;
    for (int i = 0; i < 3; i++) begin
      do_read(w_prog(1'b1, m6, 1'b0), "R1/R3 program poll"); m6 = ~m6;
    end
    time_over = 1'b1;
    for (int i = 0; i < 2; i++) begin
      do_read(w_prog(1'b1, m6, 1'b1), "R5 time-out poll"); m6 = ~m6;
    end
    time_over = 1'b0; prog_busy = 1'b0; array_data = 8'h80;
    do_read(8'h80, "R1 true data after program");
    do_read(8'h80, "R10 idle read no toggle");

    // sector load window
    pulse_sect;
    chk({7'b0, win_open}, 8'h01, "R7 window opens");
    sect_sel = 1'b1;
    do_read(w_erase(m6, 1'b0, 1'b0, m2), "R2/R4/R6 window read selected"); m6 = ~m6; m2 = ~m2;
    do_read(w_erase(m6, 1'b0, 1'b0, m2), "R4 second selected read"); m6 = ~m6; m2 = ~m2;
    sect_sel = 1'b0;
    do_read(w_erase(m6, 1'b0, 1'b0, m2), "R4 unselected read"); m6 = ~m6;
    do_read(w_erase(m6, 1'b0, 1'b0, m2), "R4 bit2 unchanged after unselected"); m6 = ~m6;
    repeat (3000) @(posedge clk);
    #1;
    chk({7'b0, win_open}, 8'h01, "R7 still open mid-window");
    pulse_sect;
    repeat (WINC - 1) @(posedge clk);
    #1;
    chk({7'b0, win_open}, 8'h01, "R7 open one cycle before close after restart");
    chk({7'b0, win_go}, 8'h00, "R7 no start pulse yet");
    @(posedge clk); #1;
    chk({7'b0, win_open}, 8'h00, "R7 closed on time");
    chk({7'b0, win_go}, 8'h01, "R7 start pulse");
    @(posedge clk); #1;
    chk({7'b0, win_go}, 8'h00, "R7 start pulse single cycle");

    // erase proper
    erase_busy = 1'b1; sect_sel = 1'b1;
    do_read(w_erase(m6, 1'b0, 1'b1, m2), "R6 erase proper bit3"); m6 = ~m6; m2 = ~m2;
    pulse_sect;
    @(negedge clk);
    chk({7'b0, win_open}, 8'h00, "R8 sector write ignored while erasing");
    do_read(w_erase(m6, 1'b0, 1'b1, m2), "R2/R3 erase poll"); m6 = ~m6; m2 = ~m2;

    // suspend
    erase_busy = 1'b0; erase_susp = 1'b1; array_data = 8'h3C;
    do_read({1'b1, m6, 3'b0, m2, 2'b0}, "R11 suspended sector read"); m2 = ~m2;
    do_read({1'b1, m6, 3'b0, m2, 2'b0}, "R3/R11 bit6 held in suspend"); m2 = ~m2;
    sect_sel = 1'b0;
    do_read(8'h3C, "R10 suspend read outside marked sector");
    sect_sel = 1'b1;
    do_read({1'b1, m6, 3'b0, m2, 2'b0}, "R4 bit2 kept across unselected suspend read"); m2 = ~m2;

    // resume and finish
    erase_susp = 1'b0; erase_busy = 1'b1;
    do_read(w_erase(m6, 1'b0, 1'b1, m2), "R3 toggling after resume"); m6 = ~m6; m2 = ~m2;
    erase_busy = 1'b0; array_data = 8'hFF; sect_sel = 1'b0;
    do_read(8'hFF, "R2 erased byte after completion");

    // protected program
    last_data = 8'h00; array_data = 8'hA5;
    @(posedge clk); #1 prot_hit = 1'b1;
    @(posedge clk); #1 prot_hit = 1'b0;
    do_read(w_prog(1'b0, m6, 1'b0), "R9 protect toggle read"); m6 = ~m6;
    do_read(w_prog(1'b0, m6, 1'b0), "R9 protect toggle read 2"); m6 = ~m6;
    repeat (PROTC) @(posedge clk);
    do_read(8'hA5, "R9 array data after protect window");

    repeat (4) @(posedge clk);
    if (expq.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL scoreboard: %0d reads left, expected 0", expq.size());
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule